// File: doc/BRIEF.md
# Sample Averaging Accumulator

This block sits between a 10-bit converter result stream and the result FIFO of a sampling sequencer. It has two modes. In averaging mode it adds up a power-of-two number of consecutive valid conversions, from 2 to 64, and emits their truncated mean as one 10-bit result. This lowers the output rate by the group size. In bypass mode it forwards each conversion unchanged. One instance serves every input channel. The single averaging setting applies to all of them, whether a channel is single-ended or differential.

The setting is a 3-bit log2 code `k` on `avg_code`, read every cycle. The block keeps its control in three states:

- `ST_PASS`: bypass, code 0.
- `ST_EMPTY`: averaging, with no partial group held.
- `ST_PARTIAL`: averaging, with at least one sample absorbed.

The transitions are:

- Any state moves to `ST_PASS` when the code is 0.
- `ST_PASS` moves to `ST_EMPTY` when a nonzero code arrives with no sample in that cycle.
- `ST_PASS` or `ST_EMPTY` moves to `ST_PARTIAL` when a sample arrives under a nonzero code.
- `ST_PARTIAL` stays in `ST_PARTIAL` while further samples arrive.
- `ST_PARTIAL` moves to `ST_EMPTY` when the last sample of a group is absorbed.
- `ST_PARTIAL` moves to `ST_EMPTY` when the code changes with no sample in that cycle, which discards the partial group.
- `ST_PARTIAL` restarts in `ST_PARTIAL` when the code changes in the same cycle as a sample.

Top module: `sample_averager`

## Requirements
- R1: With `avg_code` = 0 (bypass), every cycle with `in_valid` high gives `out_valid` high in that same cycle, with `out_data` equal to `in_data`.
- R2: With `avg_code` = k for k in 1..6, each group of 2^k consecutive valid samples yields one result equal to floor(sum of the group / 2^k).
- R3: The result is a one-cycle `out_valid` pulse in the same cycle as the final sample of the group. No other sample of the group raises `out_valid`.
- R4: Codes 7 and above act exactly like code 6, that is, groups of 64 samples.
- R5: After a result is emitted, the next group starts from an empty sum. No residue carries over from earlier groups.
- R6: A change of `avg_code` discards any partial group. If a sample arrives in the cycle of the change, it is the first sample of a new group under the new code. A change to 0 forwards that sample directly.
- R7: Cycles with `in_valid` low neither advance the group nor raise `out_valid`.
- R8: Sixty-four samples of 1023 average to 1023 with no overflow of the 16-bit sum.
- R9: During and right after reset, `out_valid` is low while `in_valid` is low. After reset the block is in bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_code | input | 3 | log2 of the group size; 0 selects bypass, values above 6 saturate |
| in_valid | input | 1 | Conversion result present |
| in_data | input | 10 | Conversion result |
| out_valid | output | 1 | Result present (one-cycle pulse in averaging mode) |
| out_data | output | 10 | Averaged or forwarded result |

## Verification
The bench sweeps every code from 0 to 7, running three groups each. It uses scattered data and idle gaps inside the groups, so that a wrong shift, a stale sum or a counter that advances on idle cycles all produce wrong results or mistimed pulses.

Full-scale and all-zero groups of 64 expose a sum that is too narrow; such a design would wrap and report a small value instead of 1023. Code changes are tested in three ways: during an idle cycle, in the same cycle as a sample, and to bypass. A design that kept its partial sum would report a mean polluted by the discarded samples, or would emit one sample too early.

// File: rtl/avg_pkg.sv
package avg_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_EMPTY   = 2'd1,
        ST_PARTIAL = 2'd2
    } avg_state_t;

endpackage

// File: rtl/avg_cfg_sat.sv
module avg_cfg_sat #(
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 6,
    parameter int K_W     = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [K_W-1:0]    k_eff
);

    // Codes beyond the largest supported group clamp to it (R4)
    always_comb begin
        if (int'(code) > MAX_LOG) k_eff = K_W'(MAX_LOG);
        else                      k_eff = K_W'(code);
    end

endmodule

// File: rtl/avg_ctrl.sv
module avg_ctrl
    import avg_pkg::*;
#(
    parameter int K_W   = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [K_W-1:0]   k_eff,
    input  logic [CNT_W-1:0] cnt,
    output avg_state_t       state,
    output logic [K_W-1:0]   k_held,
    output logic             pass,
    output logic             absorb,
    output logic             fresh,
    output logic             last
);

    avg_state_t       state_nx;
    logic             cfg_change;
    logic [CNT_W:0]   group_len;
    logic [CNT_W-1:0] last_idx;

    assign cfg_change = (k_eff != k_held);
    assign group_len  = (CNT_W+1)'(1) << k_eff;
    assign last_idx   = CNT_W'(group_len - 1'b1);

    // State register and held setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_PASS;
            k_held <= '0;
        end else begin
            state  <= state_nx;
            k_held <= k_eff;
        end
    end

    // Outputs
    always_comb begin
        pass   = (k_eff == '0);
        absorb = 1'b0;
        fresh  = 1'b0;
        last   = 1'b0;
        unique case (state)
            ST_PASS, ST_EMPTY: begin
                if (!pass && in_valid) begin
                    absorb = 1'b1;
                    fresh  = 1'b1;
                end
            end
            ST_PARTIAL: begin
                if (!pass && in_valid) begin
                    absorb = 1'b1;
                    fresh  = cfg_change;
                    last   = !cfg_change && (cnt == last_idx);
                end
            end
            default: ;
        endcase
    end

    // Next state
    always_comb begin
        if (pass)            state_nx = ST_PASS;
        else if (last)       state_nx = ST_EMPTY;
        else if (absorb)     state_nx = ST_PARTIAL;
        else if (cfg_change) state_nx = ST_EMPTY;
        else                 state_nx = state;
    end

    // A group closes only under the setting it was started with (R6)
    p_close_same_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (state == ST_PARTIAL) && (k_eff == k_held));

    // Bypass is entered whenever the code reads zero (R1)
    p_zero_code_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (k_eff == '0) |=> (state == ST_PASS));

endmodule

// File: rtl/avg_datapath.sv
module avg_datapath #(
    parameter int DATA_W  = 10,
    parameter int MAX_LOG = 6,
    parameter int K_W     = 3,
    parameter int CNT_W   = 6,
    parameter int ACC_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              absorb,
    input  logic              fresh,
    input  logic              last,
    input  logic [K_W-1:0]    k_eff,
    input  logic [DATA_W-1:0] in_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] avg_data
);

    localparam int NSHIFT = 1 << K_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  base;
    logic [ACC_W:0]    sum_wide;
    logic [ACC_W-1:0]  sum;
    logic [DATA_W-1:0] shifted [NSHIFT];

    assign base     = fresh ? '0 : acc_q;
    assign sum_wide = {1'b0, base} + (ACC_W+1)'(in_data);
    assign sum      = sum_wide[ACC_W-1:0];

    // One truncating shifter per code; codes past MAX_LOG reuse the largest
    for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
        localparam int SH = (g > MAX_LOG) ? MAX_LOG : g;
        assign shifted[g] = DATA_W'(sum >> SH);
    end

    assign avg_data = shifted[k_eff];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (absorb) begin
            if (last) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum;
                cnt_q <= fresh ? CNT_W'(1) : CNT_W'(cnt_q + 1'b1);
            end
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        absorb |-> !sum_wide[ACC_W]);

endmodule

// File: rtl/sample_averager.sv
module sample_averager
    import avg_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] avg_code,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int K_W   = $clog2(MAX_LOG + 1);
    localparam int CNT_W = MAX_LOG;
    localparam int ACC_W = DATA_W + MAX_LOG;

    logic [K_W-1:0]    k_eff;
    logic [K_W-1:0]    k_held;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] avg_data;
    logic              pass, absorb, fresh, last;
    avg_state_t        state;

    avg_cfg_sat #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .K_W(K_W)) u_sat (
        .code  (avg_code),
        .k_eff (k_eff)
    );

    avg_ctrl #(.K_W(K_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .k_eff    (k_eff),
        .cnt      (cnt_q),
        .state    (state),
        .k_held   (k_held),
        .pass     (pass),
        .absorb   (absorb),
        .fresh    (fresh),
        .last     (last)
    );

    avg_datapath #(
        .DATA_W(DATA_W), .MAX_LOG(MAX_LOG), .K_W(K_W),
        .CNT_W(CNT_W), .ACC_W(ACC_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .absorb   (absorb),
        .fresh    (fresh),
        .last     (last),
        .k_eff    (k_eff),
        .in_data  (in_data),
        .cnt_q    (cnt_q),
        .avg_data (avg_data)
    );

    assign out_valid = pass ? in_valid : last;
    assign out_data  = pass ? in_data  : avg_data;

    p_valid_needs_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    p_partial_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARTIAL) |-> (cnt_q != '0) && ((cnt_q >> k_held) == '0));

    p_fresh_after_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && k_eff != '0) |=> (cnt_q == '0));

    p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARTIAL && k_eff != k_held && k_eff != '0) |-> !out_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && k_eff == k_held) |=> $stable(cnt_q));

endmodule

// File: tb/tb_sample_averager.sv
module tb_sample_averager;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] avg_code = 3'd0;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = 10'd0;
    logic       out_valid;
    logic [9:0] out_data;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sample_averager dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .avg_code  (avg_code),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; outputs are combinational, sampled 2 ns later
    task automatic push(input int d, input bit ev, input int ed, input string req);
        in_valid = 1'b1;
        in_data  = 10'(d);
        #2;
        check(out_valid == ev, {req, " valid"}, int'(out_valid), int'(ev));
        if (ev) check(out_data == 10'(ed), {req, " data"}, int'(out_data), ed);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input string req);
        in_valid = 1'b0;
        #2;
        check(out_valid == 1'b0, {req, " idle"}, int'(out_valid), 0);
        @(negedge clk);
    endtask

    task automatic set_code(input int c);
        avg_code = 3'(c);
        idle("R6");
    endtask

    task automatic run_groups(input int c, input int groups, input int seed);
        int k = (c > 6) ? 6 : c;
        int n = 1 << k;
        string req = (k == 0) ? "R1" : ((c > 6) ? "R4" : "R2");
        for (int g = 0; g < groups; g++) begin
            int sum = 0;
            for (int i = 0; i < n; i++) begin
                int d = (seed + g * 97 + i * 29 + i * i * 7) % 1024;
                sum += d;
                if (i == n - 1) push(d, 1'b1, sum >> k, (g > 0 && k > 0) ? "R5" : req);
                else            push(d, 1'b0, 0, "R3");
                if (i % 5 == 3) idle("R7");
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R9 in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R9");
        push(123, 1'b1, 123, "R9 bypass after reset");

        // Sweep every code
        for (int c = 0; c < 8; c++) begin
            set_code(c);
            run_groups(c, 3, c * 53 + 11);
        end

        // R8: full scale and zero
        set_code(6);
        for (int i = 0; i < 64; i++) push(1023, i == 63, 1023, i == 63 ? "R8" : "R3");
        for (int i = 0; i < 64; i++) push(0, i == 63, 0, i == 63 ? "R8" : "R3");

        // R6: change while idle discards the partial group
        set_code(3);
        for (int i = 0; i < 5; i++) push(1000, 1'b0, 0, "R6");
        set_code(2);
        push(4, 1'b0, 0, "R6");
        push(8, 1'b0, 0, "R6");
        push(12, 1'b0, 0, "R6");
        push(16, 1'b1, 10, "R6");

        // R6: change in the same cycle as a sample
        push(100, 1'b0, 0, "R6");
        push(200, 1'b0, 0, "R6");
        avg_code = 3'd1;
        push(300, 1'b0, 0, "R6 same cycle");
        push(500, 1'b1, 400, "R6 same cycle");

        // R6: change to bypass mid-group
        push(7, 1'b0, 0, "R6");
        avg_code = 3'd0;
        push(9, 1'b1, 9, "R6 to bypass");
        idle("R7");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule